// File: doc/BRIEF.md
# Table-Driven Turing Machine Engine

This block is a hardware Turing machine whose behaviour is set by a rule memory loaded at run time. A bounded tape memory holds one symbol per cell. A head position register and a machine-state register track where the machine is and what it is doing. Because the rule memory is ordinary writable storage and not fixed logic, the same hardware can act as any small machine whose rules fit in it.

Before a run, the host fills the tape and the rule memory through two load ports, then pulses `start` with the initial head position. The engine then steps on its own. Each step reads the cell under the head, looks up the rule for the current state and that symbol, writes the rule's symbol back, moves the head one cell and takes the rule's next state. The run ends when the machine enters the reserved halt state or tries to leave the tape. The host then reads the tape back through the same port it used to fill it.

Top module: `tm_engine`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `head_pos` is 0 and `mach_state` is 0.
- R2: While idle, a pulse on `tape_wr_en` stores `tape_wdata` in cell `tape_addr`. A pulse on `tape_rd_en` makes `tape_rd_valid` go high in the next cycle, with `tape_rdata` holding that cell's symbol.
- R3: A rule word is laid out as {next_state, move_right, write_symbol}. `write_symbol` is in bits [SYM_W-1:0] and `move_right` is bit SYM_W, where 1 means right and 0 means left. `next_state` is in the top STATE_W bits. The word is stored at rule address {state, symbol}.
- R4: When `start` is pulsed while idle, the head is set to `start_pos`, the state is set to 0, `done` and `err` are cleared, and `busy` goes high. Every step takes exactly 3 cycles, so a run of n steps keeps `busy` high for 3n cycles.
- R5: Each step overwrites the cell under the head with the rule's symbol. It moves the head by one cell in the rule's direction and loads the rule's next state.
- R6: The all-ones state code means halt. A step into it completes normally, then `busy` drops and `done` rises. `done` stays high until the next start.
- R7: A step that would move the head below cell 0 or above the last cell still writes its symbol. It leaves the head and the state unchanged, sets `err` and `done`, and ends the run.
- R8: While `busy` is high, tape writes, tape reads and rule writes from the host are ignored, and no `tape_rd_valid` is produced.
- R9: A `start` pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| start_pos | input | ADDR_W | Initial head cell |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run ended (halt or error) |
| err | output | 1 | Last run ended by leaving the tape |
| head_pos | output | ADDR_W | Current head cell |
| mach_state | output | STATE_W | Current machine state |
| tape_wr_en | input | 1 | Host tape write strobe |
| tape_rd_en | input | 1 | Host tape read strobe |
| tape_addr | input | ADDR_W | Host tape cell address |
| tape_wdata | input | SYM_W | Symbol to store |
| tape_rdata | output | SYM_W | Symbol read back |
| tape_rd_valid | output | 1 | `tape_rdata` is valid for the previous read |
| rule_wr_en | input | 1 | Host rule write strobe |
| rule_addr | input | STATE_W+SYM_W | Rule address {state, symbol} |
| rule_wdata | input | STATE_W+1+SYM_W | Rule word {next_state, move_right, write_symbol} |

## Verification
The hardest case to reach is a host request that arrives in the middle of a run, because the engine accepts requests only when idle and a run normally ends quickly. The bench therefore uses a machine that walks left across several cells before it falls off the tape. Partway through that run, it drives a tape write, a tape read, a rule rewrite that would turn the walk into an early halt, and a second `start`. The run must still end in the boundary error after exactly the expected number of steps. Reading back the cell that was targeted during the run shows its old symbol.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_LOOK  = 2'd2,
        PH_WRITE = 2'd3
    } tm_phase_e;
endpackage

// File: rtl/tm_sync_ram.sv
module tm_sync_ram #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/tm_step_ctrl.sv
module tm_step_ctrl
    import tm_pkg::*;
#(
    parameter int SYM_W      = 2,
    parameter int STATE_W    = 3,
    parameter int TAPE_DEPTH = 32,
    localparam int ADDR_W    = $clog2(TAPE_DEPTH),
    localparam int ENTRY_W   = STATE_W + 1 + SYM_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        start_pos,
    input  logic [SYM_W-1:0]         rd_sym,
    input  logic [ENTRY_W-1:0]       rule_entry,
    output logic [ADDR_W-1:0]        tape_addr,
    output logic                     tape_we,
    output logic [SYM_W-1:0]         tape_wsym,
    output logic [STATE_W+SYM_W-1:0] rule_addr,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic [ADDR_W-1:0]        head,
    output logic [STATE_W-1:0]       cur_state
);
    localparam logic [STATE_W-1:0] HALT_CODE = {STATE_W{1'b1}};
    localparam logic [ADDR_W-1:0]  LAST_CELL = ADDR_W'(TAPE_DEPTH - 1);
    localparam logic [ADDR_W-1:0]  ONE_CELL  = ADDR_W'(1);

    typedef struct packed {
        tm_phase_e          phase;
        logic [ADDR_W-1:0]  head;
        logic [STATE_W-1:0] st;
        logic               done;
        logic               err;
    } ctrl_t;

    ctrl_t q, d;

    logic               move_right;
    logic [STATE_W-1:0] next_st;
    logic               off_edge;

    assign move_right = rule_entry[SYM_W];
    assign next_st    = rule_entry[ENTRY_W-1:SYM_W+1];
    assign off_edge   = move_right ? (q.head == LAST_CELL) : (q.head == '0);

    always_comb begin
        d         = q;
        tape_we   = 1'b0;
        tape_wsym = rule_entry[SYM_W-1:0];
        tape_addr = q.head;
        rule_addr = {q.st, rd_sym};
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase = PH_READ;
                    d.head  = start_pos;
                    d.st    = '0;
                    d.done  = 1'b0;
                    d.err   = 1'b0;
                end
            end
            PH_READ:  d.phase = PH_LOOK;
            PH_LOOK:  d.phase = PH_WRITE;
            PH_WRITE: begin
                tape_we = 1'b1;
                if (off_edge) begin
                    d.err   = 1'b1;
                    d.done  = 1'b1;
                    d.phase = PH_IDLE;
                end else begin
                    d.head = move_right ? q.head + ONE_CELL : q.head - ONE_CELL;
                    d.st   = next_st;
                    if (next_st == HALT_CODE) begin
                        d.done  = 1'b1;
                        d.phase = PH_IDLE;
                    end else begin
                        d.phase = PH_READ;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, head: '0, st: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.phase != PH_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign head      = q.head;
    assign cur_state = q.st;

    assert_read_then_look_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_READ |=> q.phase == PH_LOOK);
    assert_look_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_LOOK |=> q.phase == PH_WRITE);
    assert_head_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.phase == PH_WRITE |=> (q.err || q.head == $past(q.head) + ONE_CELL
                                        || q.head == $past(q.head) - ONE_CELL));
    assert_halt_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.err) |-> (q.st == HALT_CODE && q.phase == PH_IDLE));
    assert_edge_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> (q.head == $past(q.head) && q.st == $past(q.st) && q.done));
endmodule

// File: rtl/tm_engine.sv
module tm_engine #(
    parameter int SYM_W      = 2,
    parameter int STATE_W    = 3,
    parameter int TAPE_DEPTH = 32,
    localparam int ADDR_W    = $clog2(TAPE_DEPTH),
    localparam int RULE_AW   = STATE_W + SYM_W,
    localparam int ENTRY_W   = STATE_W + 1 + SYM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_pos,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [ADDR_W-1:0]  head_pos,
    output logic [STATE_W-1:0] mach_state,
    input  logic               tape_wr_en,
    input  logic               tape_rd_en,
    input  logic [ADDR_W-1:0]  tape_addr,
    input  logic [SYM_W-1:0]   tape_wdata,
    output logic [SYM_W-1:0]   tape_rdata,
    output logic               tape_rd_valid,
    input  logic               rule_wr_en,
    input  logic [RULE_AW-1:0] rule_addr,
    input  logic [ENTRY_W-1:0] rule_wdata
);
    logic [ADDR_W-1:0]  ctl_tape_addr;
    logic               ctl_tape_we;
    logic [SYM_W-1:0]   ctl_tape_wsym;
    logic [RULE_AW-1:0] ctl_rule_addr;
    logic [SYM_W-1:0]   cell_sym;
    logic [ENTRY_W-1:0] rule_word;

    logic [ADDR_W-1:0]  tram_addr;
    logic               tram_we;
    logic [SYM_W-1:0]   tram_wdata;
    logic [RULE_AW-1:0] rram_addr;
    logic               rram_we;
    logic               rd_valid_d, rd_valid_q;

    always_comb begin
        tram_addr  = busy ? ctl_tape_addr : tape_addr;
        tram_we    = busy ? ctl_tape_we   : tape_wr_en;
        tram_wdata = busy ? ctl_tape_wsym : tape_wdata;
        rram_addr  = busy ? ctl_rule_addr : rule_addr;
        rram_we    = rule_wr_en && !busy;
        rd_valid_d = tape_rd_en && !busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_valid_d;
        end
    end

    tm_sync_ram #(.WIDTH(SYM_W), .DEPTH(TAPE_DEPTH)) u_tape (
        .clk   (clk),
        .we    (tram_we),
        .addr  (tram_addr),
        .wdata (tram_wdata),
        .rdata (cell_sym)
    );

    tm_sync_ram #(.WIDTH(ENTRY_W), .DEPTH(1 << RULE_AW)) u_rules (
        .clk   (clk),
        .we    (rram_we),
        .addr  (rram_addr),
        .wdata (rule_wdata),
        .rdata (rule_word)
    );

    tm_step_ctrl #(.SYM_W(SYM_W), .STATE_W(STATE_W), .TAPE_DEPTH(TAPE_DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_pos  (start_pos),
        .rd_sym     (cell_sym),
        .rule_entry (rule_word),
        .tape_addr  (ctl_tape_addr),
        .tape_we    (ctl_tape_we),
        .tape_wsym  (ctl_tape_wsym),
        .rule_addr  (ctl_rule_addr),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .head       (head_pos),
        .cur_state  (mach_state)
    );

    assign tape_rdata    = cell_sym;
    assign tape_rd_valid = rd_valid_q;

    assert_valid_only_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tape_rd_valid |-> $past(!busy));
    assert_busy_clears_on_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
endmodule

// File: tb/tm_engine_tb.sv
module tm_engine_tb;
    localparam int SYM_W = 2;
    localparam int STATE_W = 3;
    localparam int DEPTH = 32;
    localparam int AW = 5;
    localparam int NRULE = 32;
    localparam int HALT = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_pos = '0;
    logic busy, done, err, tape_rd_valid;
    logic [AW-1:0] head_pos;
    logic [STATE_W-1:0] mach_state;
    logic tape_wr_en = 1'b0, tape_rd_en = 1'b0, rule_wr_en = 1'b0;
    logic [AW-1:0] tape_addr = '0;
    logic [SYM_W-1:0] tape_wdata = '0, tape_rdata;
    logic [4:0] rule_addr = '0;
    logic [5:0] rule_wdata = '0;

    int n_run = 0;
    int n_fail = 0;
    int tape_m [DEPTH];
    int rule_m [NRULE];
    int exp_q [$];
    string tag_q [$];

    always #2 clk = ~clk;

    tm_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pos(start_pos),
        .busy(busy), .done(done), .err(err), .head_pos(head_pos), .mach_state(mach_state),
        .tape_wr_en(tape_wr_en), .tape_rd_en(tape_rd_en), .tape_addr(tape_addr),
        .tape_wdata(tape_wdata), .tape_rdata(tape_rdata), .tape_rd_valid(tape_rd_valid),
        .rule_wr_en(rule_wr_en), .rule_addr(rule_addr), .rule_wdata(rule_wdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected readback items
    always @(negedge clk) begin
        if (tape_rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected read valid", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(tape_rdata), exp_q.pop_front());
            end
        end
    end

    task automatic tape_wr(input int a, input int s);
        @(negedge clk);
        tape_wr_en = 1'b1; tape_addr = AW'(a); tape_wdata = SYM_W'(s);
        @(negedge clk);
        tape_wr_en = 1'b0;
        tape_m[a] = s;
    endtask

    task automatic rule_wr(input int st, input int sym, input int ns, input int dir, input int ws);
        @(negedge clk);
        rule_wr_en = 1'b1;
        rule_addr = 5'(st * 4 + sym);
        rule_wdata = {3'(ns), 1'(dir), 2'(ws)};
        @(negedge clk);
        rule_wr_en = 1'b0;
        rule_m[st * 4 + sym] = ns * 8 + dir * 4 + ws;
    endtask

    task automatic read_expect(input int a, input string tag);
        @(negedge clk);
        tape_rd_en = 1'b1; tape_addr = AW'(a);
        exp_q.push_back(tape_m[a]);
        tag_q.push_back(tag);
        @(negedge clk);
        tape_rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill_tape(input int s);
        for (int i = 0; i < DEPTH; i++) tape_wr(i, s);
    endtask

    task automatic default_rules();
        for (int st = 0; st < 8; st++)
            for (int sy = 0; sy < 4; sy++) rule_wr(st, sy, HALT, 1, sy);
    endtask

    task automatic model_run(input int pos, output int steps, output int hd,
                             output int st, output int er);
        int e, dir;
        hd = pos; st = 0; steps = 0; er = 0;
        while (steps < 1000) begin
            e = rule_m[st * 4 + tape_m[hd]];
            steps++;
            tape_m[hd] = e % 4;
            dir = (e / 4) % 2;
            if ((dir == 1 && hd == DEPTH - 1) || (dir == 0 && hd == 0)) begin
                er = 1;
                break;
            end
            hd = (dir == 1) ? hd + 1 : hd - 1;
            st = e / 8;
            if (st == HALT) break;
        end
    endtask

    task automatic run_hw(input int pos, input bit inject, output int cycles);
        @(negedge clk);
        start = 1'b1; start_pos = AW'(pos);
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (busy && cycles < 5000) begin
            cycles++;
            if (inject && cycles == 2) begin
                tape_wr_en = 1'b1; tape_addr = AW'(31); tape_wdata = 2'd1;
                tape_rd_en = 1'b1;
                rule_wr_en = 1'b1; rule_addr = 5'd0; rule_wdata = {3'd7, 1'b1, 2'd0};
                start = 1'b1; start_pos = AW'(20);
            end
            if (inject && cycles == 3) begin
                tape_wr_en = 1'b0; tape_rd_en = 1'b0; rule_wr_en = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_and_check(input string name, input int pos, input bit inject);
        int steps, hd, st, er, cyc;
        model_run(pos, steps, hd, st, er);
        run_hw(pos, inject, cyc);
        check({name, " R4 busy cycles = 3*steps"}, cyc, 3 * steps);
        check({name, " R6 done"}, int'(done), 1);
        check({name, " R7 err"}, int'(err), er);
        check({name, " R5 head"}, int'(head_pos), hd);
        check({name, " R5 state"}, int'(mach_state), st);
        repeat (4) @(negedge clk);
        check({name, " R6 done held"}, int'(done), 1);
        for (int i = 0; i < DEPTH; i++) read_expect(i, {name, " R5 tape readback"});
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        check("R1 head", int'(head_pos), 0);
        check("R1 state", int'(mach_state), 0);

        // R2 load and readback while idle
        fill_tape(3);
        tape_wr(4, 0); tape_wr(5, 1); tape_wr(6, 1);
        tape_wr(7, 0); tape_wr(8, 1); tape_wr(9, 0);
        read_expect(5, "R2 readback cell 5");
        read_expect(9, "R2 readback cell 9");
        read_expect(0, "R2 readback cell 0");

        // machine A: flip bits moving right, halt on blank (R3 field layout)
        default_rules();
        rule_wr(0, 0, 0, 1, 1);
        rule_wr(0, 1, 0, 1, 0);
        rule_wr(0, 2, 0, 1, 2);
        rule_wr(0, 3, HALT, 0, 3);
        run_and_check("A(R3)", 4, 1'b0);

        // machine B: two-state busy beaver from a blank tape
        fill_tape(0);
        default_rules();
        rule_wr(0, 0, 1, 1, 1);
        rule_wr(0, 1, 1, 0, 1);
        rule_wr(1, 0, 0, 0, 1);
        rule_wr(1, 1, HALT, 1, 1);
        run_and_check("B", 16, 1'b0);

        // machine C: walk left off the tape (R7), with host requests mid-run (R8, R9)
        fill_tape(0);
        default_rules();
        for (int sy = 0; sy < 4; sy++) rule_wr(0, sy, 0, 0, 2);
        run_and_check("C(R7 R8 R9)", 3, 1'b1);
        read_expect(31, "R8 write during run ignored");

        // restart clears err and done at start (R4)
        fill_tape(0);
        default_rules();
        @(negedge clk);
        start = 1'b1; start_pos = AW'(10);
        @(negedge clk);
        start = 1'b0;
        check("R4 start clears err", int'(err), 0);
        check("R4 start clears done", int'(done), 0);
        check("R4 start loads head", int'(head_pos), 10);
        while (busy) @(negedge clk);
        check("R6 single step halt head", int'(head_pos), 11);
        check("R6 single step halt state", int'(mach_state), HALT);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule